// File: doc/BRIEF.md
# BCD Timekeeping Calendar Counter

This block holds wall-clock time and calendar date as packed binary-coded-decimal registers and moves them forward by one second each time a one-second tick arrives while the run bit is set. It covers seconds, minutes, hours, day of week, day of month, month and year. Hours can be kept in a 24-hour form or a 12-hour form with a morning/afternoon bit. Month length follows the calendar, and a read-only leap-year flag derived from the year picks the length of February.

Software loads any field through a byte-wide write port addressed by field number. Bit 7 of the seconds byte is the run bit; it gates both the time counters and the oscillator activity monitor. The monitor raises a running flag once enough oscillator enable pulses have been seen while running, and drops it again some time after the run bit is cleared. A comparator reports when seconds, minutes and hours equal a set of match inputs, for use by alarm logic outside the block.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the seconds, minutes, hours and year bytes read 0x00, day of week reads 1, day of month reads 0x01, month reads 0x21 (month 01 with the leap flag set because year 00 is a leap year), and both the running flag and the run bit are 0.
- R2: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in BCD, tens in bits 6:4 and units in bits 3:0; a tick moves seconds forward, and 59 goes to 00 with one step of minutes.
- R3: The run bit is bit 7 of the seconds byte; while it is 0, ticks leave every time and date field unchanged.
- R4: With hour bit 6 at 0 the hour is 24-hour BCD with tens in bits 5:4; 23 goes to 00 at the end of minute 59, second 59, and carries one day.
- R5: With hour bit 6 at 1 the hour is 12-hour: bit 5 is the afternoon flag, bit 4 the tens and bits 3:0 the units; the order is 12, 01 to 11, the flag toggles on 11 to 12, and only the change from afternoon to morning carries one day.
- R6: Day of week (address 3, bits 2:0) counts 1 to 7 and wraps from 7 to 1 on the same tick that moves the day of month.
- R7: Day of month (address 4, bits 5:0, BCD) ends at 31, at 30 for months 04, 06, 09 and 11, and at 28 for month 02 (29 in a leap year); after the last day it becomes 01.
- R8: The leap flag is 1 exactly when the BCD year is divisible by 4 (00 included); it reads as bit 5 of the month byte and on the leap_year output, and a write to month bit 5 has no effect.
- R9: Month (address 5, bits 4:0, tens in bit 4) wraps from 12 to 01 and then the year (address 6) steps forward in BCD, 99 to 00.
- R10: A write to addresses 0 to 6 loads that field at the next edge; on a tick in the same cycle the written value wins over that field's increment while carries from the old values still reach the other fields; a write to address 7 changes nothing.
- R11: The running flag becomes 1 at the edge of the 32nd oscillator enable pulse counted while the run bit is 1; clearing the run bit restarts this count.
- R12: The running flag becomes 0 at the 32nd clock edge with the run bit at 0, and stays 1 until then.
- R13: alarm_match is 1 exactly when bits 6:0 of seconds, minutes and hours equal alm_sec, alm_min and alm_hour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_clk_en | input | 1 | One pulse per oscillator cycle |
| sec_tick | input | 1 | One-second tick pulse |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field number to write |
| wr_data | input | 8 | Write data byte |
| alm_sec | input | 7 | Seconds value to match |
| alm_min | input | 7 | Minutes value to match |
| alm_hour | input | 7 | Hour value to match, format and flag bits included |
| sec_reg | output | 8 | Run bit and BCD seconds |
| min_reg | output | 8 | BCD minutes |
| hour_reg | output | 8 | Format bit and hour |
| wday_reg | output | 8 | Day of week |
| date_reg | output | 8 | BCD day of month |
| month_reg | output | 8 | Leap flag and BCD month |
| year_reg | output | 8 | BCD year |
| leap_year | output | 1 | Leap-year flag |
| osc_running | output | 1 | Oscillator running status |
| alarm_match | output | 1 | Time equals match inputs |

## Verification
Every field write and every tick becomes visible on the register outputs one clock edge after the cycle that carries it, so the bench drives on the falling edge and reads the outputs on the next falling edge. The running flag trails by exactly 32 counted edges in each direction, so the bench checks it after 31 edges and again after the 32nd. The match output is combinational on the registers and the match inputs and is read in the same half-cycle that the inputs change, while a behavioural model updated at every rising edge is compared with all outputs one nanosecond later.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam logic [2:0] FLD_SEC   = 3'd0;
    localparam logic [2:0] FLD_MIN   = 3'd1;
    localparam logic [2:0] FLD_HOUR  = 3'd2;
    localparam logic [2:0] FLD_WDAY  = 3'd3;
    localparam logic [2:0] FLD_DATE  = 3'd4;
    localparam logic [2:0] FLD_MONTH = 3'd5;
    localparam logic [2:0] FLD_YEAR  = 3'd6;

    typedef struct packed {
        logic       run;
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [2:0] wday;
        logic [5:0] date;
        logic [4:0] month;
        logic [7:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{
        run: 1'b0, sec: 7'h00, min: 7'h00, hour: 7'h00,
        wday: 3'd1, date: 6'h01, month: 5'h01, year: 8'h00
    };

    // returns {carry, next units digit}
    function automatic logic [4:0] digit_step(input logic [3:0] u);
        if (u == 4'd9) return {1'b1, 4'd0};
        return {1'b0, u + 4'd1};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import bcd_rtc_pkg::*;
(
    input  rtc_time_t cur_i,
    input  logic      step_i,
    output rtc_time_t nxt_o
);
    logic [4:0] s_u, m_u, h_u, d_u, mo_u, y_u;
    logic [6:0] sec_inc, min_inc, hour_next;
    logic [5:0] date_inc, last_day;
    logic [4:0] mon_inc;
    logic [7:0] yr_inc;
    logic       sec_wrap, min_wrap, day_carry, month_end, year_wrap, pm_old;

    always_comb begin
        s_u      = digit_step(cur_i.sec[3:0]);
        m_u      = digit_step(cur_i.min[3:0]);
        h_u      = digit_step(cur_i.hour[3:0]);
        d_u      = digit_step(cur_i.date[3:0]);
        mo_u     = digit_step(cur_i.month[3:0]);
        y_u      = digit_step(cur_i.year[3:0]);
        sec_inc  = {cur_i.sec[6:4] + 3'(s_u[4]), s_u[3:0]};
        min_inc  = {cur_i.min[6:4] + 3'(m_u[4]), m_u[3:0]};
        date_inc = {cur_i.date[5:4] + 2'(d_u[4]), d_u[3:0]};
        mon_inc  = {cur_i.month[4] | mo_u[4], mo_u[3:0]};
        yr_inc   = {cur_i.year[7:4] + 4'(y_u[4]), y_u[3:0]};

        sec_wrap = (cur_i.sec == 7'h59);
        min_wrap = sec_wrap && (cur_i.min == 7'h59);
        pm_old   = cur_i.hour[5];
        day_carry = 1'b0;

        if (cur_i.hour[6]) begin
            if (cur_i.hour[4:0] == 5'h11) begin
                hour_next = {1'b1, ~pm_old, 5'h12};
                day_carry = pm_old;
            end else if (cur_i.hour[4:0] == 5'h12) begin
                hour_next = {1'b1, pm_old, 5'h01};
            end else begin
                hour_next = {1'b1, pm_old, cur_i.hour[4] | h_u[4], h_u[3:0]};
            end
        end else begin
            if (cur_i.hour[5:0] == 6'h23) begin
                hour_next = 7'h00;
                day_carry = 1'b1;
            end else begin
                hour_next = {1'b0, cur_i.hour[5:4] + 2'(h_u[4]), h_u[3:0]};
            end
        end

        last_day  = month_last(cur_i.month, year_is_leap(cur_i.year));
        month_end = (cur_i.date == last_day);
        year_wrap = (cur_i.month == 5'h12);

        nxt_o = cur_i;
        if (step_i) begin
            nxt_o.sec = sec_wrap ? 7'h00 : sec_inc;
            if (sec_wrap) nxt_o.min = (cur_i.min == 7'h59) ? 7'h00 : min_inc;
            if (min_wrap) begin
                nxt_o.hour = hour_next;
                if (day_carry) begin
                    nxt_o.wday = (cur_i.wday == 3'd7) ? 3'd1 : cur_i.wday + 3'd1;
                    nxt_o.date = month_end ? 6'h01 : date_inc;
                    if (month_end) begin
                        nxt_o.month = year_wrap ? 5'h01 : mon_inc;
                        if (year_wrap) nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : yr_inc;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_osc_monitor.sv
module rtc_osc_monitor #(
    parameter int RUN_CYCLES  = 32,
    parameter int STOP_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic osc_en_i,
    output logic running_o
);
    localparam int RUN_W  = $clog2(RUN_CYCLES);
    localparam int STOP_W = $clog2(STOP_CYCLES);
    localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(RUN_CYCLES - 1);
    localparam logic [STOP_W-1:0] STOP_LAST = STOP_W'(STOP_CYCLES - 1);

    typedef struct packed {
        logic [RUN_W-1:0]  run_cnt;
        logic [STOP_W-1:0] stop_cnt;
        logic              running;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if (run_i) begin
            mon_d.stop_cnt = '0;
            if (osc_en_i) begin
                if (mon_q.run_cnt == RUN_LAST) mon_d.running = 1'b1;
                else                           mon_d.run_cnt = mon_q.run_cnt + 1'b1;
            end
        end else begin
            mon_d.run_cnt = '0;
            if (mon_q.stop_cnt == STOP_LAST) mon_d.running  = 1'b0;
            else                             mon_d.stop_cnt = mon_q.stop_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign running_o = mon_q.running;
endmodule

// File: rtl/rtc_match_cmp.sv
module rtc_match_cmp #(
    parameter int FIELD_W = 7,
    parameter int FIELDS  = 3
) (
    input  logic [FIELDS*FIELD_W-1:0] now_i,
    input  logic [FIELDS*FIELD_W-1:0] ref_i,
    output logic                      match_o
);
    logic [FIELDS-1:0] eq;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign eq[g] = (now_i[g*FIELD_W +: FIELD_W] == ref_i[g*FIELD_W +: FIELD_W]);
    end

    assign match_o = &eq;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter int RUN_CYCLES  = 32,
    parameter int STOP_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_clk_en,
    input  logic       sec_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [6:0] alm_sec,
    input  logic [6:0] alm_min,
    input  logic [6:0] alm_hour,
    output logic [7:0] sec_reg,
    output logic [7:0] min_reg,
    output logic [7:0] hour_reg,
    output logic [7:0] wday_reg,
    output logic [7:0] date_reg,
    output logic [7:0] month_reg,
    output logic [7:0] year_reg,
    output logic       leap_year,
    output logic       osc_running,
    output logic       alarm_match
);
    rtc_time_t time_d, time_q, time_adv;

    rtc_advance i_advance (
        .cur_i  (time_q),
        .step_i (sec_tick & time_q.run),
        .nxt_o  (time_adv)
    );

    always_comb begin
        time_d = time_adv;
        if (wr_en) begin
            case (wr_addr)
                FLD_SEC:   begin time_d.run = wr_data[7]; time_d.sec = wr_data[6:0]; end
                FLD_MIN:   time_d.min   = wr_data[6:0];
                FLD_HOUR:  time_d.hour  = wr_data[6:0];
                FLD_WDAY:  time_d.wday  = wr_data[2:0];
                FLD_DATE:  time_d.date  = wr_data[5:0];
                FLD_MONTH: time_d.month = wr_data[4:0];
                FLD_YEAR:  time_d.year  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= TIME_RESET;
        else        time_q <= time_d;
    end

    rtc_osc_monitor #(
        .RUN_CYCLES  (RUN_CYCLES),
        .STOP_CYCLES (STOP_CYCLES)
    ) i_osc_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (time_q.run),
        .osc_en_i  (osc_clk_en),
        .running_o (osc_running)
    );

    rtc_match_cmp #(
        .FIELD_W (7),
        .FIELDS  (3)
    ) i_match (
        .now_i   ({time_q.hour, time_q.min, time_q.sec}),
        .ref_i   ({alm_hour, alm_min, alm_sec}),
        .match_o (alarm_match)
    );

    assign leap_year = year_is_leap(time_q.year);
    assign sec_reg   = {time_q.run, time_q.sec};
    assign min_reg   = {1'b0, time_q.min};
    assign hour_reg  = {1'b0, time_q.hour};
    assign wday_reg  = {5'b0, time_q.wday};
    assign date_reg  = {2'b0, time_q.date};
    assign month_reg = {2'b0, leap_year, time_q.month};
    assign year_reg  = time_q.year;
endmodule

// File: rtl/bcd_rtc_core_checker.sv
module bcd_rtc_core_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       wr_en,
    input logic [7:0] sec_reg,
    input logic [7:0] min_reg,
    input logic [7:0] hour_reg,
    input logic [7:0] wday_reg,
    input logic [7:0] date_reg,
    input logic [7:0] year_reg,
    input logic       leap_year,
    input logic       osc_running
);
    // R3: stopped clock holds time and date
    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_reg[7] && !wr_en) |=> ($stable(sec_reg) && $stable(min_reg) &&
                                     $stable(hour_reg) && $stable(date_reg)));

    // R2: no tick and no write, nothing moves
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !wr_en) |=> ($stable(sec_reg) && $stable(min_reg) &&
                                   $stable(wday_reg) && $stable(year_reg)));

    // R2: second 59 wraps to 00 and minutes move
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_en && sec_reg == 8'hD9) |=>
            (sec_reg[6:0] == 7'h00 && min_reg != $past(min_reg)));

    // R6: day of week only moves together with day of month
    p_wday_with_date_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wday_reg) && !$past(wr_en)) |-> !$stable(date_reg));

    // R8: leap flag depends on the year alone
    p_leap_from_year_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(year_reg) |-> $stable(leap_year));

    // R11: running flag rises only while running
    p_run_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_running) |-> $past(sec_reg[7]));

    // R12: running flag falls only while stopped
    p_run_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_running) |-> !$past(sec_reg[7]));
endmodule

bind bcd_rtc_core bcd_rtc_core_checker i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .wr_en       (wr_en),
    .sec_reg     (sec_reg),
    .min_reg     (min_reg),
    .hour_reg    (hour_reg),
    .wday_reg    (wday_reg),
    .date_reg    (date_reg),
    .year_reg    (year_reg),
    .leap_year   (leap_year),
    .osc_running (osc_running)
);

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;
    logic       clk = 1'b0, rst_n = 1'b0, osc_clk_en = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [6:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
    logic [7:0] sec_reg, min_reg, hour_reg, wday_reg, date_reg, month_reg, year_reg;
    logic       leap_year, osc_running, alarm_match;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    bcd_rtc_core i_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .osc_clk_en(osc_clk_en), .sec_tick(sec_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .sec_reg(sec_reg), .min_reg(min_reg), .hour_reg(hour_reg), .wday_reg(wday_reg),
        .date_reg(date_reg), .month_reg(month_reg), .year_reg(year_reg),
        .leap_year(leap_year), .osc_running(osc_running), .alarm_match(alarm_match)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_run, m_sec, m_min, m_fmt, m_hr, m_pm, m_wday, m_date, m_month, m_year;
    int m_rc, m_sc, m_running;

    function automatic int tobcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int frombcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int hour_byte();
        if (m_fmt != 0) return 'h40 | (m_pm << 5) | tobcd(m_hr);
        return tobcd(m_hr);
    endfunction

    task automatic model_reset();
        m_run = 0; m_sec = 0; m_min = 0; m_fmt = 0; m_hr = 0; m_pm = 0;
        m_wday = 1; m_date = 1; m_month = 1; m_year = 0;
        m_rc = 0; m_sc = 0; m_running = 0;
    endtask

    task automatic model_day();
        m_wday = (m_wday == 7) ? 1 : m_wday + 1;
        if (m_date == days_in(m_month, m_year)) begin
            m_date = 1;
            if (m_month == 12) begin
                m_month = 1;
                m_year = (m_year + 1) % 100;
            end else m_month++;
        end else m_date++;
    endtask

    task automatic model_step();
        int old_run = m_run;
        if (old_run != 0) begin
            m_sc = 0;
            if (osc_clk_en) begin
                if (m_rc == 31) m_running = 1; else m_rc++;
            end
        end else begin
            m_rc = 0;
            if (m_sc == 31) m_running = 0; else m_sc++;
        end
        if (sec_tick && old_run != 0) begin
            m_sec++;
            if (m_sec == 60) begin
                m_sec = 0;
                m_min++;
                if (m_min == 60) begin
                    m_min = 0;
                    if (m_fmt == 0) begin
                        m_hr++;
                        if (m_hr == 24) begin m_hr = 0; model_day(); end
                    end else if (m_hr == 11) begin
                        m_hr = 12;
                        m_pm = 1 - m_pm;
                        if (m_pm == 0) model_day();
                    end else if (m_hr == 12) m_hr = 1;
                    else m_hr++;
                end
            end
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin m_run = int'(wr_data[7]); m_sec = frombcd(wr_data & 8'h7f); end
                3'd1: m_min = frombcd(wr_data & 8'h7f);
                3'd2: begin
                    m_fmt = int'(wr_data[6]);
                    if (m_fmt != 0) begin
                        m_pm = int'(wr_data[5]);
                        m_hr = frombcd(wr_data & 8'h1f);
                    end else m_hr = frombcd(wr_data & 8'h3f);
                end
                3'd3: m_wday = int'(wr_data[2:0]);
                3'd4: m_date = frombcd(wr_data & 8'h3f);
                3'd5: m_month = frombcd(wr_data & 8'h1f);
                3'd6: m_year = frombcd(wr_data);
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
        #1;
        if (rst_n) begin
            check("R2 R3 seconds", sec_reg, (m_run << 7) | tobcd(m_sec));
            check("R2 minutes", min_reg, tobcd(m_min));
            check("R4 R5 hour", hour_reg, hour_byte());
            check("R6 weekday", wday_reg, m_wday);
            check("R7 date", date_reg, tobcd(m_date));
            check("R8 R9 month", month_reg, ((m_year % 4 == 0) << 5) | tobcd(m_month));
            check("R9 year", year_reg, tobcd(m_year));
            check("R8 leap flag", leap_year, (m_year % 4 == 0));
            check("R11 R12 running", osc_running, m_running);
            check("R13 match", alarm_match,
                  (tobcd(m_sec) == alm_sec) && (tobcd(m_min) == alm_min) &&
                  ((hour_byte() & 'h7f) == alm_hour));
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input bit we, input logic [2:0] a, input logic [7:0] d, input bit tk);
        wr_en = we; wr_addr = a; wr_data = d; sec_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic tick();
        step(1'b0, 3'd0, 8'h00, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic set_eod(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d);
        wr(3'd6, y); wr(3'd5, m); wr(3'd4, d);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'hD9);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 seconds", sec_reg, 8'h00);
        check("R1 hour", hour_reg, 8'h00);
        check("R1 weekday", wday_reg, 8'h01);
        check("R1 date", date_reg, 8'h01);
        check("R1 month", month_reg, 8'h21);
        check("R1 year", year_reg, 8'h00);
        check("R1 running", osc_running, 1'b0);

        // R3: ticks ignored while stopped
        tick(); tick();
        check("R3 stopped seconds", sec_reg, 8'h00);

        // R11: running after 32 pulses
        osc_clk_en = 1'b1;
        wr(3'd0, 8'hD8);
        idle(31);
        check("R11 not yet running", osc_running, 1'b0);
        idle(1);
        check("R11 running", osc_running, 1'b1);

        // R2: seconds wrap into minutes
        tick();
        check("R2 seconds 59", sec_reg, 8'hD9);
        tick();
        check("R2 seconds wrap", sec_reg, 8'h80);
        check("R2 minute carry", min_reg, 8'h01);

        // R4 R6 R9: new year at midnight, 24-hour form
        wr(3'd3, 8'h07);
        set_eod(8'h99, 8'h12, 8'h31);
        tick();
        check("R4 hour wrap", hour_reg, 8'h00);
        check("R6 weekday wrap", wday_reg, 8'h01);
        check("R7 date wrap", date_reg, 8'h01);
        check("R9 month wrap", month_reg, 8'h21);
        check("R9 year wrap", year_reg, 8'h00);

        // R7 R8: month lengths
        set_eod(8'h24, 8'h02, 8'h28); tick();
        check("R7 leap february 29", date_reg, 8'h29);
        check("R8 leap month bit", month_reg, 8'h22);
        set_eod(8'h24, 8'h02, 8'h29); tick();
        check("R7 leap february end", date_reg, 8'h01);
        check("R7 march after leap", month_reg, 8'h23);
        set_eod(8'h23, 8'h02, 8'h28); tick();
        check("R7 plain february end", date_reg, 8'h01);
        check("R7 march plain", month_reg, 8'h03);
        set_eod(8'h23, 8'h04, 8'h30); tick();
        check("R7 april end", month_reg, 8'h05);
        set_eod(8'h23, 8'h01, 8'h30); tick();
        check("R7 january 31", date_reg, 8'h31);

        // R8: leap bit read-only, year rule
        wr(3'd6, 8'h23); wr(3'd5, 8'h25);
        check("R8 write to leap bit ignored", month_reg, 8'h05);
        wr(3'd6, 8'h12);
        check("R8 year 12 leap", leap_year, 1'b1);
        wr(3'd6, 8'h10);
        check("R8 year 10 not leap", leap_year, 1'b0);

        // R5: 12-hour form
        wr(3'd3, 8'h03); wr(3'd4, 8'h10);
        wr(3'd1, 8'h59); wr(3'd2, 8'h51); wr(3'd0, 8'hD9); tick();
        check("R5 11 am to 12 pm", hour_reg, 8'h72);
        check("R5 no day carry at noon", date_reg, 8'h10);
        wr(3'd1, 8'h59); wr(3'd0, 8'hD9); tick();
        check("R5 12 pm to 01 pm", hour_reg, 8'h61);
        wr(3'd1, 8'h59); wr(3'd2, 8'h71); wr(3'd0, 8'hD9); tick();
        check("R5 11 pm to 12 am", hour_reg, 8'h52);
        check("R5 day carry at midnight", date_reg, 8'h11);
        check("R6 weekday step", wday_reg, 8'h04);

        // R10: write during tick
        wr(3'd2, 8'h10); wr(3'd1, 8'h05); wr(3'd0, 8'hD9);
        step(1'b1, 3'd1, 8'h30, 1'b1);
        check("R10 written minutes win", min_reg, 8'h30);
        check("R10 seconds still wrap", sec_reg, 8'h80);
        step(1'b1, 3'd0, 8'hA0, 1'b1);
        check("R10 written seconds win", sec_reg, 8'hA0);
        step(1'b1, 3'd7, 8'hFF, 1'b0);
        check("R10 address 7 seconds", sec_reg, 8'hA0);
        check("R10 address 7 minutes", min_reg, 8'h30);
        check("R10 address 7 hour", hour_reg, 8'h10);

        // R13: match comparator
        alm_sec = 7'h20; alm_min = 7'h30; alm_hour = 7'h10;
        #0.5;
        check("R13 match equal", alarm_match, 1'b1);
        alm_sec = 7'h21;
        #0.5;
        check("R13 match differs", alarm_match, 1'b0);
        @(negedge clk);
        tick();
        check("R13 match after tick", alarm_match, 1'b1);

        // R12: running clears 32 cycles after stop
        wr(3'd0, 8'h21);
        idle(31);
        check("R12 still running", osc_running, 1'b1);
        idle(1);
        check("R12 stopped", osc_running, 1'b0);
        tick();
        check("R3 stopped after run", sec_reg, 8'h21);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule